// File: doc/BRIEF.md
# Light-Load Burst Controller

This block governs the light-load operating mode of a quasi-resonant flyback controller. In normal operation it only watches two things: whether the regulation feedback sits below the burst-entry level, and whether the valley-count selector has climbed to its ceiling. When both conditions hold without a break for a programmable blanking window, the block moves into burst operation. Any break in either condition discards the time already counted.

Inside burst operation the block produces the switch gate itself. A pair of hysteretic feedback flags turns switching on and off. While switching is on, a fixed-period timer launches one pulse per period. The timer restarts at the moment switching is enabled, so the first pulse starts at once. A pulse ends at the first of two events: the current-sense trip, or the point where the pulse has lasted half the period.

A high-feedback flag ends burst operation from either sub-state. The block then emits a single-cycle request that tells the valley-count selector to fall back to its minimum. While the block is in burst operation it also raises a flag that disables the overload, over-temperature and shorted-winding protections.

Top module: `lb_burst_ctrl`

## Requirements
- R1: After reset, and while reset is held, `burst_o`, `gate_o`, `exit_pulse_o` and `prot_dis_o` are all 0.
- R2: The entry condition is `fb_low_i`=1 together with `valley_cnt_i` equal to its maximum (all ones, 7 for a 3-bit count). `burst_o` rises after the condition has been sampled on ENTRY_CYC+1 consecutive rising edges, and not earlier.
- R3: If either part of the entry condition is 0 on a sampled edge, the blanking count restarts. A full fresh run of ENTRY_CYC+1 edges is then needed again.
- R4: In burst with switching off, `fb_on_i`=1 enables switching. `gate_o` goes to 1 on the same edge, so the first pulse starts immediately.
- R5: While switching is enabled, a pulse starts every PERIOD_CYC cycles and lasts at most PERIOD_CYC/2 cycles (50 % duty).
- R6: If `cs_trip_i` is 1 on an edge while `gate_o` is 1, `gate_o` is 0 after that edge. The next pulse still starts on the period boundary.
- R7: In burst with switching on, `fb_off_i`=1 disables switching. `gate_o` drops to 0 and `burst_o` stays at 1. `gate_o` is never 1 outside burst.
- R8: `fb_exit_i`=1 in either burst sub-state ends burst on the next edge, and takes priority over `fb_off_i`. `exit_pulse_o` is 1 for exactly the one cycle after that edge.
- R9: `prot_dis_o` equals `burst_o` at every cycle.
- R10: Outside burst, `fb_on_i`, `fb_off_i` and `cs_trip_i` have no effect. `gate_o` and `burst_o` stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fb_low_i | input | 1 | Feedback below the burst-entry level |
| valley_cnt_i | input | VALLEY_W | Current valley count from the valley selector |
| fb_on_i | input | 1 | Feedback above the switching-enable level |
| fb_off_i | input | 1 | Feedback below the switching-disable level |
| fb_exit_i | input | 1 | Feedback above the burst-exit level |
| cs_trip_i | input | 1 | Current-sense trip for burst pulses |
| burst_o | output | 1 | Burst operation active |
| gate_o | output | 1 | Switch gate during burst |
| exit_pulse_o | output | 1 | One-cycle request to force the valley count to its minimum |
| prot_dis_o | output | 1 | Disable for overload, over-temperature and shorted-winding protection |

## Verification
The hardest situation to reach is a restart of the blanking count that happens one edge before the count would expire. The restart must leave no residue, so a full new window is needed afterwards. The stimulus holds the entry condition for exactly ENTRY_CYC edges, breaks it once through the valley count, and then holds it again. It confirms that `burst_o` is still low one edge short of the new window and high exactly at its end. The same approach is repeated with the feedback flag as the breaking condition. A second hard spot is a current trip in mid-pulse followed by the next period boundary. The stimulus places the trip on the first cycle of a pulse and checks that the following pulse starts on schedule.

// File: rtl/lb_pkg.sv
package lb_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL     = 2'd0,
        ST_ENTRY_WAIT = 2'd1,
        ST_BURST_OFF  = 2'd2,
        ST_BURST_ON   = 2'd3
    } lb_state_e;

    function automatic logic in_burst(input lb_state_e st);
        return (st == ST_BURST_OFF) || (st == ST_BURST_ON);
    endfunction

endpackage

// File: rtl/lb_entry_timer.sv
module lb_entry_timer #(
    parameter int unsigned ENTRY_CYC = 240000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int unsigned CW = $clog2(ENTRY_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(ENTRY_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (!run_i) begin
            r_d.cnt = '0;
        end else if (r_q.cnt != LAST) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign expired_o = run_i && (r_q.cnt == LAST);

    AST_TIMER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (r_q.cnt == '0)); // R3

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= LAST); // R2

endmodule

// File: rtl/lb_fsm.sv
module lb_fsm
    import lb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cond_i,
    input  logic      expired_i,
    input  logic      fb_on_i,
    input  logic      fb_off_i,
    input  logic      fb_exit_i,
    output lb_state_e state_o,
    output lb_state_e state_nx_o,
    output logic      exit_o
);
    typedef struct packed {
        lb_state_e st;
        logic      ex;
    } fsm_s;

    fsm_s r_q, r_d;

    always_comb begin
        r_d    = r_q;
        r_d.ex = 1'b0;
        unique case (r_q.st)
            ST_NORMAL: begin
                if (cond_i) r_d.st = ST_ENTRY_WAIT;
            end
            ST_ENTRY_WAIT: begin
                if (!cond_i)        r_d.st = ST_NORMAL;
                else if (expired_i) r_d.st = ST_BURST_OFF;
            end
            ST_BURST_OFF: begin
                if (fb_exit_i) begin
                    r_d.st = ST_NORMAL;
                    r_d.ex = 1'b1;
                end else if (fb_on_i) begin
                    r_d.st = ST_BURST_ON;
                end
            end
            ST_BURST_ON: begin
                if (fb_exit_i) begin
                    r_d.st = ST_NORMAL;
                    r_d.ex = 1'b1;
                end else if (fb_off_i) begin
                    r_d.st = ST_BURST_OFF;
                end
            end
            default: r_d.st = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= ST_NORMAL;
            r_q.ex <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o    = r_q.st;
    assign state_nx_o = r_d.st;
    assign exit_o     = r_q.ex;

    AST_ENTRY_VIA_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_burst(r_q.st)) |-> ($past(r_q.st) == ST_ENTRY_WAIT)); // R2

    AST_EXIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ex |=> !r_q.ex); // R8

    AST_ON_FROM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.st == ST_BURST_ON) |-> ($past(r_q.st) == ST_BURST_OFF)); // R4

endmodule

// File: rtl/lb_pulse_gen.sv
module lb_pulse_gen #(
    parameter int unsigned PERIOD_CYC = 192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic restart_i,
    input  logic trip_i,
    output logic gate_o
);
    localparam int unsigned PW    = $clog2(PERIOD_CYC);
    localparam int unsigned MAXON = PERIOD_CYC / 2;
    localparam logic [PW-1:0] PLAST = PW'(PERIOD_CYC - 1);
    localparam logic [PW-1:0] OLAST = PW'(MAXON - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
        logic          gate;
    } pg_s;

    pg_s r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (!en_i) begin
            r_d.phase = '0;
            r_d.gate  = 1'b0;
        end else if (restart_i) begin
            r_d.phase = '0;
            r_d.gate  = 1'b1;
        end else if (r_q.phase == PLAST) begin
            r_d.phase = '0;
            r_d.gate  = 1'b1;
        end else begin
            r_d.phase = r_q.phase + 1'b1;
            if (r_q.gate && (trip_i || (r_q.phase == OLAST))) begin
                r_d.gate = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign gate_o = r_q.gate;

    AST_WIDTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.gate |-> (r_q.phase < PW'(MAXON))); // R5

    AST_TRIP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.gate && trip_i) |=> !r_q.gate); // R6

    AST_START_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && restart_i) |=> (r_q.gate && r_q.phase == '0)); // R4

endmodule

// File: rtl/lb_burst_ctrl.sv
module lb_burst_ctrl
    import lb_pkg::*;
#(
    parameter int unsigned VALLEY_W   = 3,
    parameter int unsigned ENTRY_CYC  = 240000,
    parameter int unsigned PERIOD_CYC = 192
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fb_low_i,
    input  logic [VALLEY_W-1:0] valley_cnt_i,
    input  logic                fb_on_i,
    input  logic                fb_off_i,
    input  logic                fb_exit_i,
    input  logic                cs_trip_i,
    output logic                burst_o,
    output logic                gate_o,
    output logic                exit_pulse_o,
    output logic                prot_dis_o
);
    localparam logic [VALLEY_W-1:0] VALLEY_TOP = '1;

    lb_state_e state_q, state_d;
    logic      cond, run, expired, exit_q, restart, en_nx, gate_q;

    assign cond = fb_low_i && (valley_cnt_i == VALLEY_TOP);
    assign run  = (state_q == ST_ENTRY_WAIT) && cond;

    lb_entry_timer #(.ENTRY_CYC(ENTRY_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .expired_o (expired)
    );

    lb_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cond_i     (cond),
        .expired_i  (expired),
        .fb_on_i    (fb_on_i),
        .fb_off_i   (fb_off_i),
        .fb_exit_i  (fb_exit_i),
        .state_o    (state_q),
        .state_nx_o (state_d),
        .exit_o     (exit_q)
    );

    assign en_nx   = (state_d == ST_BURST_ON);
    assign restart = en_nx && (state_q != ST_BURST_ON);

    lb_pulse_gen #(.PERIOD_CYC(PERIOD_CYC)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_nx),
        .restart_i (restart),
        .trip_i    (cs_trip_i),
        .gate_o    (gate_q)
    );

    assign burst_o      = in_burst(state_q);
    assign prot_dis_o   = in_burst(state_q);
    assign gate_o       = gate_q;
    assign exit_pulse_o = exit_q;

    AST_GATE_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |-> (state_q == ST_BURST_ON)); // R7

    AST_EXIT_MARKS_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        exit_pulse_o |-> (!burst_o && $past(burst_o))); // R8

    AST_EXIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_o && fb_exit_i) |=> (!burst_o && exit_pulse_o)); // R8

    AST_NO_GATE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_o |=> !$rose(gate_o)); // R10

endmodule

// File: tb/lb_burst_ctrl_tb.sv
module lb_burst_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRY      = 8;
    localparam int PERIOD     = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fl = 1'b0, on = 1'b0, off = 1'b0, ex = 1'b0, cs = 1'b0;
    logic [2:0] vc = 3'd0;
    logic burst, gate, xp, pd;
    int   n_chk = 0;
    int   n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lb_burst_ctrl #(.VALLEY_W(3), .ENTRY_CYC(ENTRY), .PERIOD_CYC(PERIOD)) u_dut (
        .clk(clk), .rst_n(rst_n), .fb_low_i(fl), .valley_cnt_i(vc),
        .fb_on_i(on), .fb_off_i(off), .fb_exit_i(ex), .cs_trip_i(cs),
        .burst_o(burst), .gate_o(gate), .exit_pulse_o(xp), .prot_dis_o(pd)
    );

    typedef struct packed {
        logic       fl;
        logic [2:0] vc;
        logic       on;
        logic       off;
        logic       ex;
        logic       cs;
        logic [7:0] n;
        logic       eb;
        logic       eg;
        logic       ee;
        logic [3:0] req;
    } vec_t;

    // fields: fl vc on off ex cs n | burst gate exit | requirement
    localparam vec_t VECS [19] = '{
        '{1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b1, 8'd2, 1'b0, 1'b0, 1'b0, 4'd10},
        '{1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8, 1'b0, 1'b0, 1'b0, 4'd2},
        '{1'b1, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 1'b0, 1'b0, 1'b0, 4'd3},
        '{1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8, 1'b0, 1'b0, 1'b0, 4'd3},
        '{1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 1'b0, 1'b0, 4'd2},
        '{1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 1'b1, 1'b0, 4'd4},
        '{1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4, 1'b1, 1'b1, 1'b0, 4'd5},
        '{1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 1'b0, 1'b0, 4'd5},
        '{1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd4, 1'b1, 1'b0, 1'b0, 4'd5},
        '{1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 1'b1, 1'b0, 4'd5},
        '{1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd1, 1'b1, 1'b0, 1'b0, 4'd6},
        '{1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8, 1'b1, 1'b0, 1'b0, 4'd6},
        '{1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 1'b1, 1'b0, 4'd6},
        '{1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd1, 1'b1, 1'b0, 1'b0, 4'd7},
        '{1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd3, 1'b1, 1'b0, 1'b0, 4'd7},
        '{1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 1'b1, 1'b0, 4'd4},
        '{1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd1, 1'b0, 1'b0, 1'b1, 4'd8},
        '{1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1, 1'b0, 1'b0, 1'b0, 4'd8},
        '{1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd3, 1'b0, 1'b0, 1'b0, 4'd10}
    };

    task automatic chk(input logic act, input logic exp, input string what, input int req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL R%0d %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_all(input logic eb, input logic eg, input logic ee, input int req);
        chk(burst, eb, "burst_o", req);
        chk(gate, eg, "gate_o", req);
        chk(xp, ee, "exit_pulse_o", req);
        chk(pd, eb, "prot_dis_o (R9)", 9);
    endtask

    task automatic drive(input logic a_fl, input logic [2:0] a_vc, input logic a_on,
                         input logic a_off, input logic a_ex, input logic a_cs, input int n);
        fl = a_fl; vc = a_vc; on = a_on; off = a_off; ex = a_ex; cs = a_cs;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state while reset held
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_all(1'b0, 1'b0, 1'b0, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all(1'b0, 1'b0, 1'b0, 1);

        for (int i = 0; i < 19; i++) begin
            drive(VECS[i].fl, VECS[i].vc, VECS[i].on, VECS[i].off,
                  VECS[i].ex, VECS[i].cs, int'(VECS[i].n));
            chk_all(VECS[i].eb, VECS[i].eg, VECS[i].ee, int'(VECS[i].req));
        end

        // R3: feedback flag break restarts the window
        drive(1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 5);
        drive(1'b0, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        drive(1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, ENTRY);
        chk(burst, 1'b0, "burst_o after fb_low break", 3);
        drive(1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        chk(burst, 1'b1, "burst_o after full window (R2)", 2);

        // R8: exit from the switching-off sub-state
        drive(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1);
        chk_all(1'b0, 1'b0, 1'b1, 8);
        drive(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1);
        chk(xp, 1'b0, "exit pulse single cycle", 8);

        // R1: reset in the middle of switching
        drive(1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, ENTRY + 1);
        drive(1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1);
        chk(gate, 1'b1, "gate before reset (R4)", 4);
        rst_n = 1'b0;
        #1;
        chk_all(1'b0, 1'b0, 1'b0, 1);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2);
        chk_all(1'b0, 1'b0, 1'b0, 1);

        finish_run();
    end
endmodule